// File: doc/BRIEF.md
# Load-Linked Reservation Monitor

This block keeps the single reservation that one core uses for load-linked / store-conditional atomic sequences. When the core issues a load-linked access, the block stores the address and arms a link flag. The load data itself comes from the core's normal read path. While the flag is armed, the block watches one or more streams of coherent write notices from other agents. A notice that lands anywhere inside the cache line holding the stored address disarms the flag.

When the core later issues a store-conditional, the block forwards the write to memory only if the flag is still armed at that moment. One cycle later it returns a done pulse and a success bit. The success bit equals the flag value that the store-conditional saw. Every store-conditional consumes the reservation. An explicit clear input, for example one raised on an exception return, also drops the reservation.

Top module: `llsc_reservation`

## Requirements
- R1: After reset the link flag is 0, `sc_done_o`, `sc_ok_o` and `mem_wr_o` are 0, and a store-conditional issued before any load-linked fails.
- R2: A store-conditional that follows a load-linked with no intervening cancel succeeds. One cycle after the request, `sc_done_o`=1, `sc_ok_o`=1 and `mem_wr_o`=1, and `mem_addr_o`/`mem_wdata_o` carry the request's address and data.
- R3: A valid snoop notice on any snoop port disarms the flag when its address agrees with the stored address in every bit above the low log2(`LINE_BYTES`) bits, whatever its byte offset. A later store-conditional then fails.
- R4: A snoop notice to a different cache line leaves the reservation intact.
- R5: A failing store-conditional gives `sc_done_o`=1, `sc_ok_o`=0 and `mem_wr_o`=0 one cycle after the request. A cycle with no store-conditional request gives `sc_done_o`=0 and `mem_wr_o`=0.
- R6: Every store-conditional disarms the flag, whether it succeeds or fails, so a second store-conditional without a new load-linked fails.
- R7: A new load-linked replaces the stored address and re-arms the flag. Afterwards, snoops to the old line no longer cancel the reservation and snoops to the new line do.
- R8: When a snoop hit and a store-conditional arrive in the same cycle, the store-conditional fails and no write is issued.
- R9: `clear_i` disarms the flag. A store-conditional in the same cycle as `clear_i` fails, and `clear_i` takes precedence over a load-linked in the same cycle.
- R10: When load-linked and store-conditional are requested in the same cycle, the store-conditional is judged against the existing reservation, and the load-linked then installs a new, armed reservation.
- R11: A load-linked in the same cycle as a snoop notice to the previously stored line still leaves the flag armed for the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear_i | input | 1 | Drop the reservation (for example on exception return) |
| ld_link_i | input | 1 | Load-linked request this cycle |
| st_cond_i | input | 1 | Store-conditional request this cycle |
| addr_i | input | ADDR_W | Byte address of the load-linked or store-conditional |
| wdata_i | input | DATA_W | Store-conditional write data |
| snoop_vld_i | input | NUM_SNOOP | Per-port valid for a remote coherent write notice |
| snoop_addr_i | input | NUM_SNOOP*ADDR_W | Per-port write notice byte address, port k at bits k*ADDR_W upward |
| mem_wr_o | output | 1 | Memory write enable for a successful store-conditional |
| mem_addr_o | output | ADDR_W | Memory write address |
| mem_wdata_o | output | DATA_W | Memory write data |
| sc_done_o | output | 1 | Store-conditional result valid |
| sc_ok_o | output | 1 | Store-conditional result, 1 success, 0 failure |

## Verification
The bench aims at the same-cycle collisions: a snoop hit together with a store-conditional, a clear together with a load-linked or a store-conditional, and a load-linked together with a store-conditional or a snoop to the old line. A design with the wrong priority would let a cancelled store-conditional write memory, or would lose a reservation that was freshly made. It also probes the line boundary, using a snoop at the last byte of the reserved line and one at the first byte of the next line. A compare with the wrong offset width would either miss real conflicts or abort sequences that should succeed. Repeated store-conditionals and re-targeted load-linked requests catch a flag that a store-conditional does not consume, and an address register that does not follow the newest load-linked.

// File: rtl/llsc_pkg.sv
// Package: shared types for the load-linked reservation monitor.
// Assumes: nothing beyond the parameters given to the modules that use it.
package llsc_pkg;

    // Store-conditional response held for one cycle after the request
    typedef struct packed {
        logic done;
        logic ok;
    } sc_resp_t;

endpackage

// File: rtl/llsc_line_cmp.sv
// Module: llsc_line_cmp
// Says whether two byte addresses fall in the same cache line.
// Assumes: LINE_BYTES is a power of two, at least 2.
module llsc_line_cmp #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32
) (
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [ADDR_W-1:0] addr_b,
    output logic              same_line
);
    localparam int OFS_W = $clog2(LINE_BYTES);

    // Compare the line indices, dropping the byte-offset bits by shifting
    always_comb begin
        same_line = ((addr_a >> OFS_W) == (addr_b >> OFS_W));
    end
endmodule

// File: rtl/llsc_snoop_filter.sv
// Module: llsc_snoop_filter
// Matches every snoop port against the stored link address, one comparator per port.
// Assumes: snoop_addr_i packs port k at bits [k*ADDR_W +: ADDR_W].
module llsc_snoop_filter #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int NUM_SNOOP  = 2
) (
    input  logic [NUM_SNOOP-1:0]        snoop_vld_i,
    input  logic [NUM_SNOOP*ADDR_W-1:0] snoop_addr_i,
    input  logic [ADDR_W-1:0]           link_addr,
    output logic                        hit_any
);
    logic [NUM_SNOOP-1:0] line_eq;
    logic [NUM_SNOOP-1:0] port_hit;

    for (genvar gi = 0; gi < NUM_SNOOP; gi++) begin : g_port
        llsc_line_cmp #(
            .ADDR_W     (ADDR_W),
            .LINE_BYTES (LINE_BYTES)
        ) u_cmp (
            .addr_a    (snoop_addr_i[gi*ADDR_W +: ADDR_W]),
            .addr_b    (link_addr),
            .same_line (line_eq[gi])
        );
        // Qualify the line match with the port's valid
        assign port_hit[gi] = snoop_vld_i[gi] & line_eq[gi];
    end

    // Any port hitting the reserved line counts
    always_comb begin
        hit_any = |port_hit;
    end
endmodule

// File: rtl/llsc_link_reg.sv
// Module: llsc_link_reg
// Holds the link address and link flag.
// Priority: clear, then load-linked (arm), then snoop hit or store-conditional (disarm).
// Assumes: hit is already computed against the current link address.
module llsc_link_reg #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              ld_link_i,
    input  logic              st_cond_i,
    input  logic              hit,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] link_addr,
    output logic              link_flag
);
    // Update the reservation state in priority order
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_addr <= '0;
            link_flag <= 1'b0;
        end else if (clear_i) begin
            link_flag <= 1'b0;
        end else if (ld_link_i) begin
            link_addr <= addr_i;
            link_flag <= 1'b1;
        end else if (hit || st_cond_i) begin
            link_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/llsc_sc_gate.sv
// Module: llsc_sc_gate
// Judges a store-conditional and registers the memory write and the core response.
// Assumes: link_flag is the flag before this cycle's update; a snoop hit or clear in
// the same cycle makes the store-conditional fail.
module llsc_sc_gate
    import llsc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_cond_i,
    input  logic              link_flag,
    input  logic              hit,
    input  logic              clear_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              mem_wr_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic              sc_done_o,
    output logic              sc_ok_o
);
    sc_resp_t          resp_d;
    sc_resp_t          resp_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    // Decide the outcome of this cycle's store-conditional
    always_comb begin
        resp_d.done = st_cond_i;
        resp_d.ok   = st_cond_i & link_flag & ~hit & ~clear_i;
    end

    // Register the response and capture the write payload on a request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_q <= '0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            resp_q <= resp_d;
            if (st_cond_i) begin
                addr_q <= addr_i;
                data_q <= wdata_i;
            end
        end
    end

    // Drive the outputs from the registered state
    always_comb begin
        sc_done_o   = resp_q.done;
        sc_ok_o     = resp_q.ok;
        mem_wr_o    = resp_q.ok;
        mem_addr_o  = addr_q;
        mem_wdata_o = data_q;
    end
endmodule

// File: rtl/llsc_reservation.sv
// Module: llsc_reservation (top)
// Reservation monitor for one core's load-linked / store-conditional pairs.
// Assumes: the core does the load-linked read itself; snoop notices come only from
// other agents; results appear one cycle after a store-conditional request.
module llsc_reservation #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int NUM_SNOOP  = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clear_i,
    input  logic                        ld_link_i,
    input  logic                        st_cond_i,
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic [DATA_W-1:0]           wdata_i,
    input  logic [NUM_SNOOP-1:0]        snoop_vld_i,
    input  logic [NUM_SNOOP*ADDR_W-1:0] snoop_addr_i,
    output logic                        mem_wr_o,
    output logic [ADDR_W-1:0]           mem_addr_o,
    output logic [DATA_W-1:0]           mem_wdata_o,
    output logic                        sc_done_o,
    output logic                        sc_ok_o
);
    logic [ADDR_W-1:0] link_addr;
    logic              link_flag;
    logic              hit_any;

    llsc_snoop_filter #(
        .ADDR_W     (ADDR_W),
        .LINE_BYTES (LINE_BYTES),
        .NUM_SNOOP  (NUM_SNOOP)
    ) u_filter (
        .snoop_vld_i  (snoop_vld_i),
        .snoop_addr_i (snoop_addr_i),
        .link_addr    (link_addr),
        .hit_any      (hit_any)
    );

    llsc_link_reg #(
        .ADDR_W (ADDR_W)
    ) u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (clear_i),
        .ld_link_i (ld_link_i),
        .st_cond_i (st_cond_i),
        .hit       (hit_any),
        .addr_i    (addr_i),
        .link_addr (link_addr),
        .link_flag (link_flag)
    );

    llsc_sc_gate #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .st_cond_i   (st_cond_i),
        .link_flag   (link_flag),
        .hit         (hit_any),
        .clear_i     (clear_i),
        .addr_i      (addr_i),
        .wdata_i     (wdata_i),
        .mem_wr_o    (mem_wr_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .sc_done_o   (sc_done_o),
        .sc_ok_o     (sc_ok_o)
    );
endmodule

// File: rtl/llsc_reservation_chk.sv
// Module: llsc_reservation_chk
// Temporal checks on the reservation monitor, bound into every instance of the top.
// Assumes: hit_any and link_flag are the top's internal snoop match and flag.
module llsc_reservation_chk (
    input logic clk,
    input logic rst_n,
    input logic clear_i,
    input logic ld_link_i,
    input logic st_cond_i,
    input logic hit_any,
    input logic link_flag,
    input logic sc_done_o,
    input logic sc_ok_o,
    input logic mem_wr_o
);
    // R1
    done_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sc_done_o |-> $past(st_cond_i));

    // R5
    write_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o |-> $past(link_flag));

    // R2
    armed_sc_succeeds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_cond_i && link_flag && !hit_any && !clear_i) |=> (sc_ok_o && mem_wr_o));

    // R8
    snoop_beats_sc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_cond_i && hit_any) |=> (!sc_ok_o && !mem_wr_o));

    // R9
    clear_kills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (!link_flag && !sc_ok_o));

    // R3
    hit_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_any && !ld_link_i && !clear_i) |=> !link_flag);

    // R6
    sc_consumes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_cond_i && !ld_link_i) |=> !link_flag);

    // R7
    ll_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_link_i && !clear_i) |=> link_flag);
endmodule

bind llsc_reservation llsc_reservation_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (clear_i),
    .ld_link_i (ld_link_i),
    .st_cond_i (st_cond_i),
    .hit_any   (hit_any),
    .link_flag (link_flag),
    .sc_done_o (sc_done_o),
    .sc_ok_o   (sc_ok_o),
    .mem_wr_o  (mem_wr_o)
);

// File: tb/llsc_reservation_bench.sv
module llsc_reservation_bench;
    localparam int AW  = 32;
    localparam int DW  = 32;
    localparam int LB  = 32;
    localparam int NS  = 2;
    localparam int OFS = $clog2(LB);

    logic           clk = 1'b0;
    logic           rst_n;
    logic           clear_i, ld_link_i, st_cond_i;
    logic [AW-1:0]  addr_i;
    logic [DW-1:0]  wdata_i;
    logic [NS-1:0]  snoop_vld_i;
    logic [NS*AW-1:0] snoop_addr_i;
    logic           mem_wr_o;
    logic [AW-1:0]  mem_addr_o;
    logic [DW-1:0]  mem_wdata_o;
    logic           sc_done_o, sc_ok_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    bit            m_flag;
    logic [AW-1:0] m_addr;

    always #2 clk = ~clk;

    llsc_reservation #(
        .ADDR_W(AW), .DATA_W(DW), .LINE_BYTES(LB), .NUM_SNOOP(NS)
    ) u_llsc_reservation (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .ld_link_i(ld_link_i),
        .st_cond_i(st_cond_i), .addr_i(addr_i), .wdata_i(wdata_i),
        .snoop_vld_i(snoop_vld_i), .snoop_addr_i(snoop_addr_i),
        .mem_wr_o(mem_wr_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
        .sc_done_o(sc_done_o), .sc_ok_o(sc_ok_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit line_eq(input logic [AW-1:0] a, input logic [AW-1:0] b);
        return (a >> OFS) == (b >> OFS);
    endfunction

    // Drive one cycle of stimulus, update the model, check the registered response
    task automatic step(input bit ll, input bit sc, input bit clr,
                        input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input bit v0, input logic [AW-1:0] s0,
                        input bit v1, input logic [AW-1:0] s1,
                        input string req);
        bit hit, ok;
        @(negedge clk);
        ld_link_i    = ll;
        st_cond_i    = sc;
        clear_i      = clr;
        addr_i       = a;
        wdata_i      = d;
        snoop_vld_i  = {v1, v0};
        snoop_addr_i = {s1, s0};
        hit = (v0 && line_eq(s0, m_addr)) || (v1 && line_eq(s1, m_addr));
        ok  = sc && m_flag && !hit && !clr;
        if (clr)            m_flag = 1'b0;
        else if (ll)        begin m_flag = 1'b1; m_addr = a; end
        else if (hit || sc) m_flag = 1'b0;
        @(posedge clk);
        #1;
        chk(req, "sc_done", 64'(sc_done_o), 64'(sc));
        chk(req, "sc_ok",   64'(sc_ok_o),   64'(ok));
        chk(req, "mem_wr",  64'(mem_wr_o),  64'(ok));
        if (ok) begin
            chk(req, "mem_addr",  64'(mem_addr_o),  64'(a));
            chk(req, "mem_wdata", 64'(mem_wdata_o), 64'(d));
        end
    endtask

    task automatic ll_op(input logic [AW-1:0] a, input string req);
        step(1, 0, 0, a, '0, 0, '0, 0, '0, req);
    endtask

    task automatic sc_op(input logic [AW-1:0] a, input logic [DW-1:0] d, input string req);
        step(0, 1, 0, a, d, 0, '0, 0, '0, req);
    endtask

    task automatic snoop_op(input bit port, input logic [AW-1:0] s, input string req);
        if (port) step(0, 0, 0, '0, '0, 0, '0, 1, s, req);
        else      step(0, 0, 0, '0, '0, 1, s, 0, '0, req);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] pool [4];
        pool[0] = 32'h0000_1000;
        pool[1] = 32'h0000_1020;
        pool[2] = 32'h0000_2000;
        pool[3] = 32'h0000_2FE0;

        void'($urandom(32'd1234));
        rst_n = 1'b0;
        clear_i = 0; ld_link_i = 0; st_cond_i = 0;
        addr_i = '0; wdata_i = '0; snoop_vld_i = '0; snoop_addr_i = '0;
        m_flag = 0; m_addr = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1: outputs quiet during reset
        chk("R1", "sc_done", 64'(sc_done_o), 64'd0);
        chk("R1", "mem_wr",  64'(mem_wr_o),  64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: store-conditional before any load-linked fails
        sc_op(32'h1000, 32'hAAAA_0001, "R1");
        // R2: plain pair succeeds
        ll_op(32'h1004, "R2");
        sc_op(32'h1004, 32'hDEAD_BEEF, "R2");
        // R6: a second store-conditional fails (R5 checks no write)
        sc_op(32'h1004, 32'h1111_2222, "R6");
        // R3: snoop to last byte of the reserved line cancels
        ll_op(32'h1000, "R3");
        snoop_op(0, 32'h101F, "R3");
        sc_op(32'h1000, 32'h3333_0000, "R3");
        // R3: same through port 1, first byte
        ll_op(32'h1010, "R3");
        snoop_op(1, 32'h1000, "R3");
        sc_op(32'h1010, 32'h3333_0001, "R3");
        // R4: snoop to the next line leaves the reservation
        ll_op(32'h1000, "R4");
        snoop_op(1, 32'h1020, "R4");
        snoop_op(0, 32'h0FFF, "R4");
        sc_op(32'h1000, 32'h4444_0000, "R4");
        // R7: re-targeted load-linked, old line no longer cancels
        ll_op(32'h1000, "R7");
        ll_op(32'h2000, "R7");
        snoop_op(0, 32'h1008, "R7");
        sc_op(32'h2000, 32'h7777_0001, "R7");
        // R7: new line does cancel
        ll_op(32'h1000, "R7");
        ll_op(32'h2000, "R7");
        snoop_op(1, 32'h201C, "R7");
        sc_op(32'h2000, 32'h7777_0002, "R7");
        // R8: snoop hit in the same cycle as the store-conditional
        ll_op(32'h1000, "R8");
        step(0, 1, 0, 32'h1000, 32'h8888_0000, 1, 32'h1004, 0, '0, "R8");
        // R9: clear, then store-conditional
        ll_op(32'h1000, "R9");
        step(0, 0, 1, '0, '0, 0, '0, 0, '0, "R9");
        sc_op(32'h1000, 32'h9999_0001, "R9");
        // R9: clear together with store-conditional
        ll_op(32'h1000, "R9");
        step(0, 1, 1, 32'h1000, 32'h9999_0002, 0, '0, 0, '0, "R9");
        // R9: clear beats load-linked
        step(1, 0, 1, 32'h1000, '0, 0, '0, 0, '0, "R9");
        sc_op(32'h1000, 32'h9999_0003, "R9");
        // R10: load-linked with store-conditional judged on old reservation
        ll_op(32'h1000, "R10");
        step(1, 1, 0, 32'h2000, 32'hA0A0_0001, 0, '0, 0, '0, "R10");
        sc_op(32'h2000, 32'hA0A0_0002, "R10");
        step(1, 1, 0, 32'h2000, 32'hA0A0_0003, 0, '0, 0, '0, "R10");
        sc_op(32'h2000, 32'hA0A0_0004, "R10");
        // R11: load-linked with snoop to the old line
        ll_op(32'h1000, "R11");
        step(1, 0, 0, 32'h1000, '0, 1, 32'h1010, 0, '0, "R11");
        sc_op(32'h1000, 32'hB0B0_0001, "R11");

        // Constrained random mix
        for (int i = 0; i < 3000; i++) begin
            bit ll, sc, clr, v0, v1;
            logic [AW-1:0] a, s0, s1;
            string req;
            ll  = ($urandom % 4) == 0;
            sc  = ($urandom % 3) == 0;
            clr = ($urandom % 20) == 0;
            v0  = ($urandom % 5) == 0;
            v1  = ($urandom % 5) == 0;
            a   = pool[$urandom % 4] | AW'($urandom % LB);
            s0  = pool[$urandom % 4] | AW'($urandom % LB);
            s1  = pool[$urandom % 4] | AW'($urandom % LB);
            if (clr)          req = "R9";
            else if (ll && sc) req = "R10";
            else if (sc)      req = "R6";
            else if (v0 || v1) req = "R3";
            else if (ll)      req = "R7";
            else              req = "R5";
            step(ll, sc, clr, a, $urandom, v0, s0, v1, s1, req);
        end

        finished = 1;
        summary();
        $finish;
    end
endmodule